// File: doc/BRIEF.md
# Dual-Panel Parallel Display Bus Bridge

This block connects a 32-bit word-addressed register bus to two 16-bit parallel display panels that share one data bus. Software writes registers to send command words or pixel words to the panels, reads words back from a panel into a receive buffer, and runs counted frame transfers. A transfer is armed by a start request. Each pixel-carrying access then counts a pixel counter down. When the counter reaches zero, the busy flag drops and a completion interrupt is raised.

On the panel side the block drives one active-low select per panel, a command/data line, active-low write and read strobes, and the outgoing data bus with its output enable. It also samples an incoming data bus. Every panel access runs the same sequence: a setup cycle, a strobe of programmable width, and a hold cycle. The register bus is held off with its ready signal until that sequence has finished.

Top module: `panel_bus_bridge`

## Requirements
- R1: An access is accepted while `bus_sel` is high, and `bus_ready` is a one-cycle pulse that ends it. Register accesses return `bus_ready` in the cycle after acceptance. Only accesses with `bus_be` = 4'hF at a word-aligned address take effect. Any other access, and any offset above 0x5C, reads 0 and changes nothing.
- R2: After reset the registers read as follows: status (0x04) = 0x1, control (0x08) = 0x2, both configuration registers (0x28, 0x2C) = 0x00310000. Every other register reads 0, including the receive buffer (0x20/0x24). `irq_done` is low.
- R3: The control register (0x08) keeps only wdata[3:0]: bit 0 enable, bit 1 bypass, bit 2 panel 0 select enable, bit 3 panel 1 select enable. Bit 4 is a start request and is never stored. A start is refused when both configuration registers have bit 2 set, or both have bit 3 set.
- R4: A control write with bit 4 set raises busy only if the written bit 0 is 1, the written bit 1 is 0, busy is clear, `dispc_en` is high and R3 allows it.
- R5: A write to 0x14 sends wdata[15:0] with `pnl_dc` = 0. A write to 0x18 sends wdata[15:0] with `pnl_dc` = 1. `pnl_cs_n[i]` is low during the access exactly when control bit 2+i is set.
- R6: A write to 0x1C sends two data-phase writes (`pnl_dc` = 1): wdata[15:0] first, then wdata[31:16]. It then decrements the pixel counter (0x0C) modulo 2^32. When the counter becomes zero, busy clears.
- R7: A write to 0x20 (`pnl_dc` = 1) or to 0x24 (`pnl_dc` = 0) performs one read strobe and no write strobe. The read goes to panel 0 if control bit 2 is set, otherwise to panel 1 if bit 3 is set, otherwise to no panel. `pnl_din` is captured into the receive buffer, which reads back at 0x20 and at 0x24. The buffer is unchanged when no panel is enabled. Each such read decrements the pixel counter with the same busy rule as R6.
- R8: The status register (0x04) reads 0x1 with busy in bit 8. `irq_done` rises only when a decrement clears busy; a counter reaching zero while idle leaves it low. Writing 1 to bit 0 of 0x04 clears it, and writing 0 there has no effect.
- R9: The idle register (0x00) stores wdata & 0x19. A write to it with bit 1 set returns every other register, busy and `irq_done` to their reset values.
- R10: Write masks: 0x28/0x2C keep 0x003f1fff. 0x30 and 0x38 keep 0x3fffffff. 0x34 and 0x3C keep 0x0fffffff. The six data-cycle registers at 0x40..0x54 keep 0x0f1f0f1f. 0x10 keeps 11 bits, 0x58/0x5C keep 16 bits, and 0x0C keeps all 32 bits.
- R11: Let W = (0x30 bits [3:0]) + 1. A panel access takes one setup cycle, a strobe held low for W cycles, and one hold cycle with the strobe high. Counting the accepting cycle as 1, `bus_ready` comes in cycle W+3 for a single access and in cycle 2W+5 for a 0x1C access.
- R12: `pnl_wr_n` and `pnl_rd_n` are never low together. `pnl_doe` is high and `pnl_dout` is stable while `pnl_wr_n` is low. A read selects at most one panel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle access completion pulse |
| bus_rdata | output | 32 | Read data, valid with ready |
| dispc_en | input | 1 | Display controller enable qualifying a start |
| pnl_cs_n | output | 2 | Active-low panel selects |
| pnl_dc | output | 1 | 0 = command/status phase, 1 = data phase |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_doe | output | 1 | Output enable for pnl_dout |
| pnl_dout | output | 16 | Panel data out |
| pnl_din | input | 16 | Panel data in |
| irq_done | output | 1 | Transfer completion interrupt status |

## Verification
The bench sweeps every strobe width from 1 to 16 cycles and checks both the ready latency and the measured strobe length. An off-by-one in the strobe counter would shift both counts by one. It walks all four select-enable patterns for writes and reads: a design with the wrong read priority would fill the receive buffer with the other panel's word, and one that forgot the no-panel case would overwrite it with idle bus data. All sixteen combinations of enable, bypass, controller enable and configuration conflict are tried against the start rule. A wrong half order in the 32-bit write would send the pixel halves swapped. The counter is taken to zero both while busy and while idle, which catches an interrupt raised without a transfer. It is also decremented from zero, where an incorrect design would saturate instead of wrapping.

// File: rtl/panel_bus_bridge.sv
module panel_bus_bridge #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ready,
  output logic [31:0]   bus_rdata,
  input  logic          dispc_en,
  output logic [1:0]    pnl_cs_n,
  output logic          pnl_dc,
  output logic          pnl_wr_n,
  output logic          pnl_rd_n,
  output logic          pnl_doe,
  output logic [15:0]   pnl_dout,
  input  logic [15:0]   pnl_din,
  output logic          irq_done
);

  localparam int IW = AW - 2;
  localparam logic [IW-1:0] R_IDLE = IW'(0),  R_STAT = IW'(1),  R_CTRL = IW'(2),  R_PIX = IW'(3);
  localparam logic [IW-1:0] R_SKIP = IW'(4),  R_CMD  = IW'(5),  R_DAT  = IW'(6),  R_D32 = IW'(7);
  localparam logic [IW-1:0] R_RDD  = IW'(8),  R_RDS  = IW'(9),  R_CFG0 = IW'(10), R_CFG1 = IW'(11);
  localparam logic [IW-1:0] R_TIM  = IW'(12), R_TIM_E = IW'(16), R_DCY = IW'(16), R_DCY_E = IW'(22);
  localparam logic [IW-1:0] R_VS   = IW'(22), R_HS   = IW'(23);
  localparam logic [31:0] CFG_RST  = 32'h0031_0000;
  localparam logic [31:0] CFG_MASK = 32'h003f_1fff;
  localparam logic [31:0] TIMA_MASK = 32'h3fff_ffff;
  localparam logic [31:0] TIMB_MASK = 32'h0fff_ffff;
  localparam logic [31:0] DCY_MASK = 32'h0f1f_0f1f;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;
  typedef enum logic [2:0] {OP_CMD, OP_DAT, OP_D32, OP_RDD, OP_RDS} op_t;

  st_t         st_q;
  op_t         op_q;
  logic        half_q;
  logic [3:0]  cnt_q;
  logic [31:0] wd_q;

  logic [4:0]  idle_q;
  logic [3:0]  ctrl_q;
  logic [31:0] pix_q;
  logic [10:0] skip_q;
  logic [31:0] cfg_q [2];
  logic [31:0] tim_q [4];
  logic [31:0] dcy_q [6];
  logic [15:0] vs_q, hs_q, rx_q;
  logic        busy_q, irq_q;
  logic [31:0] rd_val;

  wire [IW-1:0] idx     = bus_addr[AW-1:2];
  wire          acc     = bus_sel && !bus_ready && st_q == S_IDLE;
  wire          full    = (&bus_be) && bus_addr[1:0] == 2'b00;
  wire          wr_acc  = acc && bus_wr && full;
  wire          pnl_go  = wr_acc && idx >= R_CMD && idx <= R_RDS;
  wire          soft_rst = wr_acc && idx == R_IDLE && bus_wdata[1];
  wire          is_rd   = op_q == OP_RDD || op_q == OP_RDS;
  wire          fin     = st_q == S_HOLD && !(op_q == OP_D32 && !half_q);
  wire          counts  = op_q == OP_D32 || is_rd;
  wire [31:0]   pix_dec = pix_q - 32'd1;
  wire          cfg_ok  = (cfg_q[0][3:2] & cfg_q[1][3:2]) == 2'b00;
  wire          start   = wr_acc && idx == R_CTRL && bus_wdata[4] && cfg_ok && bus_wdata[0]
                          && !bus_wdata[1] && !busy_q && dispc_en;
  wire          act     = st_q != S_IDLE;

  always_comb begin
    rd_val = '0;
    if (idx >= R_TIM && idx < R_TIM_E) rd_val = tim_q[2'(idx - R_TIM)];
    else if (idx >= R_DCY && idx < R_DCY_E) rd_val = dcy_q[3'(idx - R_DCY)];
    else begin
      case (idx)
        R_IDLE:        rd_val = {27'b0, idle_q};
        R_STAT:        rd_val = {23'b0, busy_q, 8'h01};
        R_CTRL:        rd_val = {28'b0, ctrl_q};
        R_PIX:         rd_val = pix_q;
        R_SKIP:        rd_val = {21'b0, skip_q};
        R_RDD, R_RDS:  rd_val = {16'b0, rx_q};
        R_CFG0:        rd_val = cfg_q[0];
        R_CFG1:        rd_val = cfg_q[1];
        R_VS:          rd_val = {16'b0, vs_q};
        R_HS:          rd_val = {16'b0, hs_q};
        default:       rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      op_q      <= OP_CMD;
      half_q    <= 1'b0;
      cnt_q     <= '0;
      wd_q      <= '0;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= 1'b0;
      case (st_q)
        S_IDLE: if (acc) begin
          bus_rdata <= (!bus_wr && full) ? rd_val : '0;
          if (pnl_go) begin
            op_q   <= op_t'(3'(idx - R_CMD));
            wd_q   <= bus_wdata;
            half_q <= 1'b0;
            st_q   <= S_SETUP;
          end else begin
            bus_ready <= 1'b1;
          end
        end
        S_SETUP: begin
          cnt_q <= tim_q[0][3:0];
          st_q  <= S_STROBE;
        end
        S_STROBE: begin
          if (cnt_q == 4'd0) st_q <= S_HOLD;
          else cnt_q <= cnt_q - 4'd1;
        end
        S_HOLD: begin
          if (fin) begin
            st_q      <= S_IDLE;
            bus_ready <= 1'b1;
          end else begin
            half_q <= 1'b1;
            st_q   <= S_SETUP;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idle_q <= '0;
    else if (wr_acc && idx == R_IDLE) idle_q <= bus_wdata[4:0] & 5'h19;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ctrl_q <= 4'b0010;
      pix_q  <= '0;
      skip_q <= '0;
      cfg_q[0] <= CFG_RST;
      cfg_q[1] <= CFG_RST;
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      for (int i = 0; i < 6; i++) dcy_q[i] <= '0;
      vs_q   <= '0;
      hs_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_acc) begin
        case (idx)
          R_STAT: if (bus_wdata[0]) irq_q <= 1'b0;
          R_CTRL: ctrl_q <= bus_wdata[3:0];
          R_PIX:  pix_q  <= bus_wdata;
          R_SKIP: skip_q <= bus_wdata[10:0];
          R_CFG0: cfg_q[0] <= bus_wdata & CFG_MASK;
          R_CFG1: cfg_q[1] <= bus_wdata & CFG_MASK;
          R_VS:   vs_q <= bus_wdata[15:0];
          R_HS:   hs_q <= bus_wdata[15:0];
          default: ;
        endcase
        if (idx >= R_TIM && idx < R_TIM_E)
          tim_q[2'(idx - R_TIM)] <= bus_wdata & (idx[0] ? TIMB_MASK : TIMA_MASK);
        if (idx >= R_DCY && idx < R_DCY_E)
          dcy_q[3'(idx - R_DCY)] <= bus_wdata & DCY_MASK;
      end
      if (start) busy_q <= 1'b1;
      if (st_q == S_STROBE && cnt_q == 4'd0 && is_rd && (ctrl_q[2] || ctrl_q[3]))
        rx_q <= pnl_din;
      if (fin && counts) begin
        pix_q <= pix_dec;
        if (pix_dec == 32'd0 && busy_q) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end
      end
    end
  end

  assign irq_done = irq_q;
  assign pnl_cs_n = !act  ? 2'b11 :
                    is_rd ? (ctrl_q[2] ? 2'b10 : ctrl_q[3] ? 2'b01 : 2'b11) :
                    ~ctrl_q[3:2];
  assign pnl_dc   = !(op_q == OP_CMD || op_q == OP_RDS);
  assign pnl_wr_n = !(st_q == S_STROBE && !is_rd);
  assign pnl_rd_n = !(st_q == S_STROBE && is_rd);
  assign pnl_doe  = act && !is_rd;
  assign pnl_dout = half_q ? wd_q[31:16] : wd_q[15:0];

endmodule

// File: rtl/panel_bus_bridge_chk.sv
module panel_bus_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ready,
  input logic [1:0]  pnl_cs_n,
  input logic        pnl_wr_n,
  input logic        pnl_rd_n,
  input logic        pnl_doe,
  input logic [15:0] pnl_dout,
  input logic        irq_done,
  input logic        busy
);

  // R1
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_wr_n || pnl_rd_n);

  // R7
  read_one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_rd_n |-> $countones(~pnl_cs_n) <= 1);

  // R12
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_wr_n |-> pnl_doe);

  // R12
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_wr_n && $past(!pnl_wr_n)) |-> $stable(pnl_dout));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $fell(busy));

endmodule

bind panel_bus_bridge panel_bus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .pnl_cs_n(pnl_cs_n),
  .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n), .pnl_doe(pnl_doe),
  .pnl_dout(pnl_dout), .irq_done(irq_done), .busy(busy_q)
);

// File: tb/tb_panel_bus_bridge.sv
`timescale 1ns/1ps
module tb_panel_bus_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bus_sel = 1'b0, bus_wr = 1'b0, dispc_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [1:0]  pnl_cs_n;
  logic        pnl_dc, pnl_wr_n, pnl_rd_n, pnl_doe, irq_done;
  logic [15:0] pnl_dout, pnl_din;
  logic [15:0] din0 = 16'h0, din1 = 16'h0;

  assign pnl_din = !pnl_cs_n[0] ? din0 : !pnl_cs_n[1] ? din1 : 16'hFFFF;

  panel_bus_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .dispc_en(dispc_en), .pnl_cs_n(pnl_cs_n), .pnl_dc(pnl_dc), .pnl_wr_n(pnl_wr_n),
    .pnl_rd_n(pnl_rd_n), .pnl_doe(pnl_doe), .pnl_dout(pnl_dout), .pnl_din(pnl_din),
    .irq_done(irq_done)
  );

  int checks = 0, errors = 0;
  logic [1:0]  lg_cs [256];
  logic        lg_dc [256];
  logic [15:0] lg_d  [256];
  int          lg_n = 0, low_len = 0, last_len = 0;
  logic        pv_wr = 1'b1, pv_dc = 1'b0;
  logic [1:0]  pv_cs = 2'b11;
  logic [15:0] pv_d = '0;

  always @(negedge clk) begin
    if (!pv_wr && pnl_wr_n) begin
      lg_cs[lg_n % 256] = pv_cs;
      lg_dc[lg_n % 256] = pv_dc;
      lg_d[lg_n % 256]  = pv_d;
      lg_n++;
    end
    if (!pnl_wr_n || !pnl_rd_n) low_len++;
    else if (low_len != 0) begin
      last_len = low_len;
      low_len = 0;
    end
    pv_wr = pnl_wr_n; pv_cs = pnl_cs_n; pv_dc = pnl_dc; pv_d = pnl_dout;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ready && cyc < 1000);
    rd = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] v; int c;
    bus(1'b1, a, d, 4'hF, v, c);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    int c;
    bus(1'b0, a, 32'h0, 4'hF, v, c);
  endtask

  function automatic logic [31:0] rst_exp(input int i);
    case (i)
      1: return 32'h1;
      2: return 32'h2;
      10, 11: return 32'h0031_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int i);
    if (i == 3) return 32'hFFFF_FFFF;
    if (i == 4) return 32'h7FF;
    if (i == 10 || i == 11) return 32'h003f_1fff;
    if (i == 12 || i == 14) return 32'h3fff_ffff;
    if (i == 13 || i == 15) return 32'h0fff_ffff;
    if (i >= 16 && i <= 21) return 32'h0f1f_0f1f;
    if (i == 22 || i == 23) return 32'hFFFF;
    return 32'h0;
  endfunction

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_rx;
    int c, base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values of every register
    for (int i = 0; i < 24; i++) begin
      rd(8'(i * 4), v);
      chk($sformatf("R2 reg %0d", i), v, rst_exp(i));
    end
    chk("R2 irq", {31'b0, irq_done}, 32'h0);

    // R10 masks
    for (int i = 3; i < 24; i++) begin
      if (mask_of(i) != 0) begin
        wr(8'(i * 4), 32'hFFFF_FFFF);
        rd(8'(i * 4), v);
        chk($sformatf("R10 mask %0d", i), v, mask_of(i));
      end
    end
    // R3: bit 4 not stored; with bypass set no start
    wr(8'h08, 32'h1F);
    rd(8'h08, v); chk("R3 ctrl keeps 4 bits", v, 32'hF);
    rd(8'h04, v); chk("R3 no start in bypass", v, 32'h1);
    // R9 idle mask then soft reset
    wr(8'h00, 32'hFFFF_FFFD);
    rd(8'h00, v); chk("R9 idle mask", v, 32'h19);
    wr(8'h00, 32'h2);
    for (int i = 0; i < 24; i++) begin
      rd(8'(i * 4), v);
      chk($sformatf("R9 soft reset reg %0d", i), v, rst_exp(i));
    end

    // R11 strobe width sweep, R5 command write to panel 0
    wr(8'h08, 32'h4);
    for (int w = 0; w < 16; w++) begin
      wr(8'h30, 32'(w));
      base = lg_n;
      bus(1'b1, 8'h14, 32'hAB00_1200 + 32'(w), 4'hF, v, c);
      chk($sformatf("R11 ready cycles w=%0d", w), 32'(c), 32'(w + 4));
      chk($sformatf("R11 strobe len w=%0d", w), 32'(last_len), 32'(w + 1));
      chk("R5 one write", 32'(lg_n - base), 32'd1);
      chk("R5 cmd data", {16'b0, lg_d[base % 256]}, 32'h1200 + 32'(w));
      chk("R5 cmd cs/dc", {29'b0, lg_cs[base % 256], lg_dc[base % 256]}, 32'b100);
    end
    wr(8'h30, 32'h2);
    wr(8'h0C, 32'h9);
    base = lg_n;
    bus(1'b1, 8'h1C, 32'h5566_7788, 4'hF, v, c);
    chk("R11 32-bit access cycles", 32'(c), 32'd11);
    chk("R11 strobe len two halves", 32'(last_len), 32'd3);
    wr(8'h30, 32'h0);

    // R5 select sweep
    for (int s = 0; s < 4; s++) begin
      wr(8'h08, 32'(s << 2));
      base = lg_n;
      wr(8'h14, 32'hFFFF_C0D0 + 32'(s));
      wr(8'h18, 32'h0000_DA70 + 32'(s));
      chk($sformatf("R5 writes s=%0d", s), 32'(lg_n - base), 32'd2);
      chk("R5 cs cmd", {30'b0, lg_cs[base % 256]}, {30'b0, ~2'(s)});
      chk("R5 dc cmd", {31'b0, lg_dc[base % 256]}, 32'h0);
      chk("R5 data cmd", {16'b0, lg_d[base % 256]}, 32'hC0D0 + 32'(s));
      chk("R5 cs dat", {30'b0, lg_cs[(base + 1) % 256]}, {30'b0, ~2'(s)});
      chk("R5 dc dat", {31'b0, lg_dc[(base + 1) % 256]}, 32'h1);
      chk("R5 data dat", {16'b0, lg_d[(base + 1) % 256]}, 32'hDA70 + 32'(s));
    end

    // R6 half order
    wr(8'h08, 32'hC);
    wr(8'h0C, 32'h5);
    base = lg_n;
    wr(8'h1C, 32'hBEEF_1234);
    chk("R6 two writes", 32'(lg_n - base), 32'd2);
    chk("R6 low half first", {16'b0, lg_d[base % 256]}, 32'h1234);
    chk("R6 high half second", {16'b0, lg_d[(base + 1) % 256]}, 32'hBEEF);
    chk("R6 data phase", {30'b0, lg_dc[base % 256], lg_dc[(base + 1) % 256]}, 32'b11);
    chk("R6 both panels", {30'b0, lg_cs[base % 256]}, 32'b00);
    rd(8'h0C, v); chk("R6 count decremented", v, 32'h4);

    // R7 read priority sweep
    wr(8'h0C, 32'd20);
    exp_rx = 32'h0;
    for (int s = 0; s < 4; s++) begin
      wr(8'h08, 32'(s << 2));
      din0 = 16'h1A00 + 16'(s); din1 = 16'h2B00 + 16'(s);
      base = lg_n;
      wr(8'h20, 32'h0);
      if (s[0]) exp_rx = {16'b0, din0}; else if (s[1]) exp_rx = {16'b0, din1};
      rd(8'h20, v); chk($sformatf("R7 data read s=%0d", s), v, exp_rx);
      din0 = 16'h3C00 + 16'(s); din1 = 16'h4D00 + 16'(s);
      wr(8'h24, 32'h0);
      if (s[0]) exp_rx = {16'b0, din0}; else if (s[1]) exp_rx = {16'b0, din1};
      rd(8'h24, v); chk($sformatf("R7 status read s=%0d", s), v, exp_rx);
      chk("R7 no write strobes", 32'(lg_n - base), 32'd0);
    end
    rd(8'h0C, v); chk("R7 count after 8 reads", v, 32'd12);

    // R4 start sweep
    for (int m = 0; m < 16; m++) begin
      wr(8'h00, 32'h2);
      wr(8'h28, 32'h4);
      wr(8'h2C, m[3] ? 32'h4 : 32'h8);
      dispc_en = m[2];
      wr(8'h08, 32'h1C | 32'(m[1:0]));
      rd(8'h04, v);
      chk($sformatf("R4 start m=%0d", m), v,
          (m[0] && !m[1] && m[2] && !m[3]) ? 32'h101 : 32'h1);
      rd(8'h08, v); chk("R3 start bit not kept", v, 32'hC | 32'(m[1:0]));
    end
    wr(8'h00, 32'h2);
    wr(8'h28, 32'h3); wr(8'h2C, 32'h3);
    wr(8'h08, 32'h15);
    rd(8'h04, v); chk("R3 other config bits no conflict", v, 32'h101);

    // R6 / R8 counted transfer
    wr(8'h00, 32'h2);
    wr(8'h0C, 32'h3);
    wr(8'h08, 32'h1D);
    for (int k = 1; k <= 3; k++) begin
      wr(8'h1C, 32'h0102_0304 * 32'(k));
      rd(8'h04, v); chk($sformatf("R8 busy after %0d", k), v, (k < 3) ? 32'h101 : 32'h1);
      rd(8'h0C, v); chk("R6 count", v, 32'(3 - k));
      chk("R8 irq", {31'b0, irq_done}, (k < 3) ? 32'h0 : 32'h1);
    end
    wr(8'h04, 32'h0);
    chk("R8 write 0 keeps irq", {31'b0, irq_done}, 32'h1);
    wr(8'h04, 32'h1);
    chk("R8 write 1 clears irq", {31'b0, irq_done}, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h15);
    wr(8'h24, 32'h0);
    rd(8'h04, v); chk("R7 read ends transfer", v, 32'h1);
    chk("R8 irq from read", {31'b0, irq_done}, 32'h1);
    wr(8'h00, 32'h2);
    chk("R9 soft reset clears irq", {31'b0, irq_done}, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h4);
    wr(8'h1C, 32'h0);
    rd(8'h0C, v); chk("R8 idle count zero", v, 32'h0);
    chk("R8 no irq while idle", {31'b0, irq_done}, 32'h0);
    wr(8'h1C, 32'h0);
    rd(8'h0C, v); chk("R6 count wraps", v, 32'hFFFF_FFFF);

    // R1 bus rules
    wr(8'h08, 32'h4);
    bus(1'b1, 8'h08, 32'h9, 4'h7, v, c);
    rd(8'h08, v); chk("R1 partial write ignored", v, 32'h4);
    bus(1'b0, 8'h08, 32'h0, 4'h3, v, c); chk("R1 partial read zero", v, 32'h0);
    rd(8'h60, v); chk("R1 undefined read", v, 32'h0);
    rd(8'h09, v); chk("R1 misaligned read", v, 32'h0);
    wr(8'h0C, 32'h33);
    wr(8'h0D, 32'h7);
    rd(8'h0C, v); chk("R1 misaligned write ignored", v, 32'h33);
    base = lg_n;
    bus(1'b1, 8'h14, 32'h1, 4'hE, v, c);
    chk("R1 partial panel write no strobe", 32'(lg_n - base), 32'd0);
    chk("R1 register ready latency", 32'(c), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule